// File: doc/BRIEF.md
# Adjacent-Disturb Memory Test Sequencer

This block is a built-in test engine for a word-organised memory. It stresses the memory with a worst-case neighbour-disturb pattern, treating consecutive word addresses as neighbouring cells. A run starts by conditioning every location. It writes all ones to every location, then all zeros, and it repeats that pair a set number of times. Next it writes each even address once. That value, the probe value, is never rewritten during the run.

After the probe load the engine cycles through four passes with no end:
- verify every address;
- rewrite the odd (neighbour) addresses in phase with their probes;
- verify every address again;
- rewrite the neighbours in anti-phase.

Each read is compared against the value the location must hold at that point. Mismatches are counted in a saturating counter. The first failing read is captured together with its address, its expected data and its read data.

The engine drives a single request/ready memory port and issues one access per accepted request. Read data comes back a fixed number of cycles after acceptance, and the engine keeps reads in flight back to back. A stop request ends the run cleanly at the end of a loop pass.

Top module: `disturb_test_seq`

## Requirements
- R1: After `start`, the engine writes all ones and then all zeros to every address, in ascending order. This pair is repeated HIST_REPS times.
- R2: Right after conditioning, each even address is written exactly once with its probe value. The probe value is all ones when address bit 1 is 0 and all zeros when address bit 1 is 1.
- R3: Once the loop has begun, no even address is written again.
- R4: The loop passes run in a fixed order: read every address; write each odd address with the probe value of the even address below it; read every address; write each odd address with the complement of that value. The order then repeats.
- R5: In a read pass, an even address is expected to hold its probe value. An odd address is expected to hold the data of the latest neighbour write pass, or all zeros if no neighbour write pass has run yet.
- R6: Each mismatching read adds one to `err_cnt`. The counter saturates at its all-ones value.
- R7: The first mismatch after a clear latches `fail_valid`, `fail_addr`, `fail_exp` and `fail_got`. These hold until `clear`, and `clear` also zeroes `err_cnt`.
- R8: `start` launches a run only while idle. A run launch zeroes `pass_cnt`. `start` has no effect while `busy` is high.
- R9: A `stop` pulse while busy ends the run at the close of the loop pass in progress. If no loop pass has begun yet, the run ends at the close of the first loop pass. All reads in flight are checked before `busy` falls, and no request is issued afterwards.
- R10: `pass_cnt` rises by exactly one each time a loop pass completes.
- R11: A request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready` accepts it. Read data is sampled RD_LAT clock edges after the accepting edge.
- R12: After reset, `busy`, `mem_req` and `fail_valid` are low, and `err_cnt` and `pass_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run when idle |
| stop | input | 1 | Request the end of the run at the next loop-pass end |
| clear | input | 1 | Zero the error counter and first-failure capture |
| mem_req | output | 1 | Access request to memory |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the pending request |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT edges after acceptance |
| busy | output | 1 | A run is in progress |
| pass_cnt | output | PASS_W | Completed loop passes in this run |
| err_cnt | output | ERR_W | Saturating mismatch count |
| fail_valid | output | 1 | A failure has been captured |
| fail_addr | output | ADDR_W | Address of the first failing read |
| fail_exp | output | DATA_W | Expected data of the first failing read |
| fail_got | output | DATA_W | Read data of the first failing read |

## Verification
A behavioural memory model is used that can flip bits in the data returned for one address or for all addresses, and that can stall its ready line with several duty patterns.

Runs are stopped after one to six loop passes, which separates the neighbour expectations:
- a fault on an odd address caught in the first verify pass shows that the conditioning value (all zeros) is expected there;
- runs ending after the in-phase and after the anti-phase rewrite show which neighbour value the memory holds at the end.

A flip on the very last address read shows that in-flight reads are still checked after a stop. An all-address flip shows counter saturation while the capture still keeps the first failure. Per-address write counts separate the probe addresses, which are written once after conditioning, from the neighbours, which are rewritten each pass. The same counts show that a `start` pulse during a run restarts nothing.

// File: rtl/dts_pkg.sv
package dts_pkg;

  // Walk phases of the sequencer; the loop order RD0 -> WSAME -> RD2 -> WOPP is behaviour.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HIST  = 3'd1,
    PH_LOAD  = 3'd2,
    PH_RD0   = 3'd3,
    PH_WSAME = 3'd4,
    PH_RD2   = 3'd5,
    PH_WOPP  = 3'd6,
    PH_DRAIN = 3'd7
  } phase_t;

endpackage

// File: rtl/dts_ctrl.sv
module dts_ctrl
  import dts_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HIST_REPS = 2,
  parameter int PASS_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              mem_ready,
  input  logic              pipe_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_push,
  output logic [DATA_W-1:0] rd_exp,
  output logic              busy,
  output logic [PASS_W-1:0] pass_cnt,
  output phase_t            phase
);

  localparam int REP_W = (HIST_REPS > 1) ? $clog2(HIST_REPS) : 1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(HIST_REPS - 1);
  localparam logic [ADDR_W-2:0] PAIR_LAST = '1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  phase_t              phase_q, phase_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                hval_q, hval_d;
  logic [REP_W-1:0]    rep_q, rep_d;
  logic                first_q, first_d;
  logic                stop_q, stop_d;
  logic [PASS_W-1:0]   pass_q, pass_d;

  logic                walking, accept, step2, at_last, stop_now;
  logic [DATA_W-1:0]   probe;
  logic [ADDR_W-1:0]   step;

  // Output decode
  always_comb begin
    walking = phase_q inside {PH_HIST, PH_LOAD, PH_RD0, PH_WSAME, PH_RD2, PH_WOPP};
    probe   = addr_q[1] ? '0 : '1;
    mem_we    = 1'b0;
    mem_wdata = '0;
    step2     = 1'b0;
    case (phase_q)
      PH_HIST:  begin mem_we = 1'b1; mem_wdata = {DATA_W{hval_q}}; end
      PH_LOAD:  begin mem_we = 1'b1; mem_wdata = probe;  step2 = 1'b1; end
      PH_WSAME: begin mem_we = 1'b1; mem_wdata = probe;  step2 = 1'b1; end
      PH_WOPP:  begin mem_we = 1'b1; mem_wdata = ~probe; step2 = 1'b1; end
      default:  ;
    endcase
    if (!addr_q[0])             rd_exp = probe;
    else if (phase_q == PH_RD0) rd_exp = first_q ? '0 : ~probe;
    else                        rd_exp = probe;
    step     = step2 ? ADDR_W'(2) : ADDR_W'(1);
    at_last  = step2 ? (addr_q[ADDR_W-1:1] == PAIR_LAST) : (addr_q == ADDR_LAST);
    mem_req  = walking;
    accept   = walking && mem_ready;
    rd_push  = accept && !mem_we;
    mem_addr = addr_q;
    busy     = (phase_q != PH_IDLE);
    pass_cnt = pass_q;
    phase    = phase_q;
    stop_now = stop_q || stop;
  end

  // Next state
  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    hval_d  = hval_q;
    rep_d   = rep_q;
    first_d = first_q;
    stop_d  = stop_q;
    pass_d  = pass_q;
    if ((phase_q != PH_IDLE) && stop) stop_d = 1'b1;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_HIST;
          addr_d  = '0;
          hval_d  = 1'b1;
          rep_d   = '0;
          first_d = 1'b1;
          stop_d  = 1'b0;
          pass_d  = '0;
        end
      end
      PH_DRAIN: begin
        if (!pipe_busy) begin
          phase_d = PH_IDLE;
          stop_d  = 1'b0;
        end
      end
      default: begin
        if (accept) begin
          if (!at_last) begin
            addr_d = addr_q + step;
          end else begin
            case (phase_q)
              PH_HIST: begin
                addr_d = '0;
                if (hval_q) begin
                  hval_d = 1'b0;
                end else if (rep_q == REP_LAST) begin
                  phase_d = PH_LOAD;
                end else begin
                  rep_d  = rep_q + REP_W'(1);
                  hval_d = 1'b1;
                end
              end
              PH_LOAD: begin
                phase_d = PH_RD0;
                addr_d  = '0;
              end
              PH_RD0: begin
                pass_d  = pass_q + PASS_W'(1);
                phase_d = stop_now ? PH_DRAIN : PH_WSAME;
                addr_d  = ADDR_W'(1);
              end
              PH_WSAME: begin
                pass_d  = pass_q + PASS_W'(1);
                phase_d = stop_now ? PH_DRAIN : PH_RD2;
                addr_d  = '0;
              end
              PH_RD2: begin
                pass_d  = pass_q + PASS_W'(1);
                phase_d = stop_now ? PH_DRAIN : PH_WOPP;
                addr_d  = ADDR_W'(1);
              end
              PH_WOPP: begin
                pass_d  = pass_q + PASS_W'(1);
                first_d = 1'b0;
                phase_d = stop_now ? PH_DRAIN : PH_RD0;
                addr_d  = '0;
              end
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      hval_q  <= 1'b0;
      rep_q   <= '0;
      first_q <= 1'b0;
      stop_q  <= 1'b0;
      pass_q  <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      hval_q  <= hval_d;
      rep_q   <= rep_d;
      first_q <= first_d;
      stop_q  <= stop_d;
      pass_q  <= pass_d;
    end
  end

endmodule

// File: rtl/dts_rd_pipe.sv
module dts_rd_pipe #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_exp,
  output logic              chk_valid,
  output logic [ADDR_W-1:0] chk_addr,
  output logic [DATA_W-1:0] chk_exp,
  output logic              busy
);

  logic [LAT-1:0]    vld_q;
  logic [ADDR_W-1:0] addr_q [LAT];
  logic [DATA_W-1:0] exp_q  [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= LAT'({vld_q, push});
  end

  // Data stages load only under their stage enable; no reset needed.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[0] <= push_addr;
      exp_q[0]  <= push_exp;
    end
    for (int i = 1; i < LAT; i++) begin
      if (vld_q[i-1]) begin
        addr_q[i] <= addr_q[i-1];
        exp_q[i]  <= exp_q[i-1];
      end
    end
  end

  assign chk_valid = vld_q[LAT-1];
  assign chk_addr  = addr_q[LAT-1];
  assign chk_exp   = exp_q[LAT-1];
  assign busy      = |vld_q;

endmodule

// File: rtl/dts_err_log.sv
module dts_err_log #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] chk_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic [ERR_W-1:0]  err_cnt,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);

  logic [ERR_W-1:0]  cnt_q, cnt_d;
  logic              fv_q, fv_d;
  logic [ADDR_W-1:0] fa_q;
  logic [DATA_W-1:0] fe_q, fg_q;
  logic              miss, cap_en;

  always_comb begin
    miss   = chk_valid && (rdata != chk_exp);
    cap_en = miss && !fv_q && !clear;
    if (clear)                  cnt_d = '0;
    else if (miss && !(&cnt_q)) cnt_d = cnt_q + ERR_W'(1);
    else                        cnt_d = cnt_q;
    fv_d = clear ? 1'b0 : (fv_q || miss);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fv_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fv_q  <= fv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0;
      fe_q <= '0;
      fg_q <= '0;
    end else if (cap_en) begin
      fa_q <= chk_addr;
      fe_q <= chk_exp;
      fg_q <= rdata;
    end
  end

  assign err_cnt    = cnt_q;
  assign fail_valid = fv_q;
  assign fail_addr  = fa_q;
  assign fail_exp   = fe_q;
  assign fail_got   = fg_q;

endmodule

// File: rtl/disturb_test_seq.sv
module disturb_test_seq
  import dts_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HIST_REPS = 2,
  parameter int RD_LAT    = 2,
  parameter int ERR_W     = 16,
  parameter int PASS_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              clear,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [PASS_W-1:0] pass_cnt,
  output logic [ERR_W-1:0]  err_cnt,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);

  logic              rd_push, pipe_busy, chk_valid;
  logic [DATA_W-1:0] rd_exp, chk_exp;
  logic [ADDR_W-1:0] chk_addr;
  phase_t            phase_w;

  dts_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIST_REPS(HIST_REPS), .PASS_W(PASS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .mem_ready(mem_ready), .pipe_busy(pipe_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_push(rd_push), .rd_exp(rd_exp), .busy(busy), .pass_cnt(pass_cnt),
    .phase(phase_w)
  );

  dts_rd_pipe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(RD_LAT)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_addr(mem_addr), .push_exp(rd_exp),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_exp(chk_exp), .busy(pipe_busy)
  );

  dts_err_log #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
  ) u_log (
    .clk(clk), .rst_n(rst_n), .clear(clear), .chk_valid(chk_valid),
    .chk_addr(chk_addr), .chk_exp(chk_exp), .rdata(mem_rdata),
    .err_cnt(err_cnt), .fail_valid(fail_valid), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

endmodule

// File: rtl/dts_checker.sv
module dts_checker
  import dts_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16,
  parameter int PASS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ERR_W-1:0]  err_cnt,
  input logic              fail_valid,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [DATA_W-1:0] fail_exp,
  input logic [DATA_W-1:0] fail_got,
  input logic [PASS_W-1:0] pass_cnt,
  input phase_t            phase
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_NO_PROBE_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (phase inside {PH_WSAME, PH_WOPP})) |-> mem_addr[0]); // R3

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + ERR_W'(1)))); // R6

  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_cnt) && !clear) |=> (&err_cnt)); // R6

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && !clear) |=> (fail_valid && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_got))); // R7

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((err_cnt == '0) && !fail_valid)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R9

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pass_cnt == $past(pass_cnt)) || (pass_cnt == $past(pass_cnt) + PASS_W'(1)))); // R10

endmodule

bind disturb_test_seq dts_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W), .PASS_W(PASS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .busy(busy), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .err_cnt(err_cnt), .fail_valid(fail_valid), .fail_addr(fail_addr),
  .fail_exp(fail_exp), .fail_got(fail_got), .pass_cnt(pass_cnt), .phase(phase_w)
);

// File: tb/disturb_test_seq_bench.sv
module disturb_test_seq_bench;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int HR    = 2;
  localparam int LAT   = 2;
  localparam int EW    = 4;
  localparam int PW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int ESAT  = (1 << EW) - 1;
  localparam int WD_CYCLES = 100000;

  typedef struct packed {
    logic [3:0] stall;
    logic       fall;
    logic [3:0] faddr;
    logic [7:0] mask;
    logic [3:0] npass;
  } row_t;

  // stall period, flip-all, flip address, flip mask, loop passes before stop
  localparam row_t ROWS [6] = '{
    '{4'd0, 1'b0, 4'd0,  8'h00, 4'd4},
    '{4'd3, 1'b0, 4'd5,  8'h01, 4'd2},
    '{4'd2, 1'b0, 4'd6,  8'h80, 4'd3},
    '{4'd0, 1'b1, 4'd0,  8'hFF, 4'd5},
    '{4'd4, 1'b0, 4'd9,  8'h10, 4'd6},
    '{4'd2, 1'b0, 4'd15, 8'h04, 4'd1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, stop, clear;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          busy, fail_valid;
  logic [PW-1:0] pass_cnt;
  logic [EW-1:0] err_cnt;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_got;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  disturb_test_seq #(
    .ADDR_W(AW), .DATA_W(DW), .HIST_REPS(HR), .RD_LAT(LAT), .ERR_W(EW), .PASS_W(PW)
  ) u_disturb_test_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .clear(clear),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .pass_cnt(pass_cnt),
    .err_cnt(err_cnt), .fail_valid(fail_valid), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // Behavioural memory with read-side fault injection and ready stalls
  logic [DW-1:0] mem   [DEPTH];
  int            wcnt  [DEPTH];
  int            base  [DEPTH];
  logic [DW-1:0] rpipe [LAT];
  logic          f_all   = 1'b0;
  logic [AW-1:0] f_addr  = '0;
  logic [DW-1:0] f_mask  = '0;
  int            stall_n = 0;
  int            cyc     = 0;

  always @(negedge clk) cyc <= cyc + 1;
  assign mem_ready = (stall_n == 0) || ((cyc % stall_n) != 0);
  assign mem_rdata = rpipe[LAT-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= '0;
        wcnt[i] <= 0;
      end
      for (int i = 0; i < LAT; i++) rpipe[i] <= '0;
    end else begin
      if (mem_req && mem_ready && mem_we) begin
        mem[mem_addr]  <= mem_wdata;
        wcnt[mem_addr] <= wcnt[mem_addr] + 1;
      end
      if (mem_req && mem_ready && !mem_we)
        rpipe[0] <= mem[mem_addr] ^ ((f_all || (mem_addr == f_addr)) ? f_mask : '0);
      else
        rpipe[0] <= '0;
      for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
    end
  end

  function automatic logic [DW-1:0] probe_of(input logic [AW-1:0] a);
    return a[1] ? '0 : '1;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_row(input int idx, input row_t r);
    int rp, wp, raw, exp_err, bad_even, bad_odd, bad_data;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_exp, e_odd;
    f_all   = r.fall;
    f_addr  = r.faddr;
    f_mask  = r.mask;
    stall_n = int'(r.stall);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int i = 0; i < DEPTH; i++) base[i] = wcnt[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (pass_cnt != PW'(r.npass - 1)) @(negedge clk);
    stop  = 1'b1;
    start = 1'b1;   // R8: must be ignored while busy
    @(negedge clk);
    stop  = 1'b0;
    start = 1'b0;
    while (busy) @(negedge clk);

    rp  = (int'(r.npass) + 1) / 2;
    wp  = int'(r.npass) / 2;
    raw = r.fall ? rp * DEPTH : ((r.mask != 0) ? rp : 0);
    exp_err = (raw > ESAT) ? ESAT : raw;
    e_addr  = r.fall ? '0 : r.faddr;
    e_exp   = e_addr[0] ? '0 : probe_of(e_addr);

    check(err_cnt == EW'(exp_err), $sformatf("R6 R5 R11 row%0d err_cnt", idx), err_cnt, exp_err);
    check(fail_valid == (raw > 0), $sformatf("R7 row%0d fail_valid", idx), fail_valid, raw > 0);
    if (raw > 0) begin
      check(fail_addr == e_addr, $sformatf("R7 row%0d fail_addr", idx), fail_addr, e_addr);
      check(fail_exp == e_exp, $sformatf("R5 R7 row%0d fail_exp", idx), fail_exp, e_exp);
      check(fail_got == (e_exp ^ r.mask), $sformatf("R7 row%0d fail_got", idx), fail_got, e_exp ^ r.mask);
    end
    check(pass_cnt == PW'(r.npass), $sformatf("R9 R10 row%0d pass_cnt", idx), pass_cnt, r.npass);
    check(!mem_req, $sformatf("R9 row%0d request after stop", idx), mem_req, 0);

    bad_even = 0; bad_odd = 0; bad_data = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) begin
        if (wcnt[i] - base[i] != 2 * HR + 1) bad_even++;
        if (mem[i] != probe_of(AW'(i))) bad_data++;
      end else begin
        if (wcnt[i] - base[i] != 2 * HR + wp) bad_odd++;
        if (wp == 0)          e_odd = '0;
        else if (wp % 2 == 1) e_odd = probe_of(AW'(i));
        else                  e_odd = ~probe_of(AW'(i));
        if (mem[i] != e_odd) bad_data++;
      end
    end
    check(bad_even == 0, $sformatf("R1 R2 R3 R8 row%0d probe write counts", idx), bad_even, 0);
    check(bad_odd == 0, $sformatf("R1 R4 R8 row%0d neighbour write counts", idx), bad_odd, 0);
    check(bad_data == 0, $sformatf("R2 R4 row%0d memory contents", idx), bad_data, 0);
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    stop  = 1'b0;
    clear = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!busy, "R12 busy", busy, 0);
    check(!mem_req, "R12 mem_req", mem_req, 0);
    check(err_cnt == '0, "R12 err_cnt", err_cnt, 0);
    check(!fail_valid, "R12 fail_valid", fail_valid, 0);
    check(pass_cnt == '0, "R12 pass_cnt", pass_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) run_row(k, ROWS[k]);

    // R7: clear zeroes the log after a failing run
    check(fail_valid, "R7 capture before clear", fail_valid, 1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(err_cnt == '0, "R7 err_cnt after clear", err_cnt, 0);
    check(!fail_valid, "R7 fail_valid after clear", fail_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule